// File: doc/BRIEF.md
# Extended Configuration Byte Switch Unit

This block is the device-side executor of the configuration switch command. It holds a byte-addressed extended configuration file (512 bytes by default) and applies one switch command to it at a time. A command is a 32-bit argument presented with a one-cycle valid strobe. The block splits the argument into an update mode, a target byte index, a value byte and a command-set code. It then reads the target byte, modifies it and writes it back. The whole step is kept inside a fixed busy window.

Only a small set of bytes may be changed by a switch. A switch fails in three cases: it targets any other byte, it carries a nonzero reserved argument bit, or it would leave the bus-width byte holding an encoding that does not exist. A failed switch changes nothing and raises the switch-error bit of a 32-bit status word. After reset the block sweeps default values into the whole file while holding busy, so the file can sit in block RAM. A separate registered read port lets any byte be read back at any time.

Top module: `ecsd_switch_unit`

## Requirements
- R1: After reset, busy_o is high while the file is loaded with defaults. When busy_o falls, byte 192 reads 0x08, byte 194 reads 0x02, byte 196 reads 0x17 and every other byte reads 0x00.
- R2: Argument fields: bits [25:24] give the mode, bits [23:16] give the target index, bits [15:8] give the value byte and bits [2:0] give the command-set code.
- R3: Mode 1 ORs the value into the target byte.
- R4: Mode 2 clears in the target byte every bit that is 1 in the value.
- R5: Mode 3 replaces the target byte with the value.
- R6: Mode 0 writes the command-set code, zero-extended, into byte 191. The index and value fields are ignored in this mode.
- R7: If any of argument bits [31:26] or [7:3] is 1, the switch fails. A failed switch leaves the file unchanged.
- R8: In modes 1 to 3, only indices 33, 179, 183, 185 and 187 are writable. Any other index fails the switch, and the file is left unchanged.
- R9: A switch on byte 183 fails, with the byte unchanged, when its result is not one of 0, 1, 2, 5 or 6.
- R10: status_o bit 7 is 1 if the most recently accepted switch failed and 0 if it succeeded. All other status bits are 0. status_o does not change while busy_o is low.
- R11: A switch is accepted on a rising edge where cmd_valid_i is high and busy_o is low. busy_o is then high for exactly BUSY_CYCLES cycles (minimum 2).
- R12: A cmd_valid_i that arrives while busy_o is high is ignored. It does not change the file, the status or the length of the busy window.
- R13: rd_data_o shows the byte at rd_idx_i one clock after rd_idx_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Switch command strobe |
| cmd_arg_i | input | 32 | Switch command argument |
| busy_o | output | 1 | Default load or switch in progress |
| status_o | output | 32 | Status word, bit 7 = switch error |
| rd_idx_i | input | AW | Read-back byte index |
| rd_data_o | output | 8 | Read-back byte, one cycle latency |

## Verification
The bench probes each way a switch can fail:
- A reserved bit set alone in the high field and alone in the low field. A design that checks only one field would modify the byte.
- Writes to the read-only identity bytes. A design without per-index protection would overwrite the revision byte.
- Bus-width results built by OR and AND as well as by direct write. A design that checks legality only on the value byte would store an illegal width of 7 or 4.

It also checks that a successful switch clears the error bit. A command-set switch carrying a nonzero index and value is sent, and the bench confirms that byte is untouched. A second strobe is sent inside the busy window; a design that restarts its timer or performs a second update would show it in the busy length or in the target byte.

// File: rtl/ecsd_pkg.sv
package ecsd_pkg;

  typedef enum logic [1:0] {
    AM_CMDSET  = 2'd0,
    AM_SETBITS = 2'd1,
    AM_CLRBITS = 2'd2,
    AM_WRBYTE  = 2'd3
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e  mode;
    logic [7:0] idx;
    logic [7:0] val;
    logic [2:0] cset;
    logic       rsv_bad;
  } sw_cmd_t;

  localparam logic [7:0] IX_CACHE  = 8'd33;
  localparam logic [7:0] IX_PART   = 8'd179;
  localparam logic [7:0] IX_BUSW   = 8'd183;
  localparam logic [7:0] IX_TIMING = 8'd185;
  localparam logic [7:0] IX_PWR    = 8'd187;
  localparam logic [7:0] IX_CSET   = 8'd191;
  localparam logic [7:0] IX_REV    = 8'd192;
  localparam logic [7:0] IX_STRUCT = 8'd194;
  localparam logic [7:0] IX_CTYPE  = 8'd196;

  function automatic logic [7:0] reset_byte(input logic [15:0] i);
    case (i)
      16'(IX_REV):    return 8'h08;
      16'(IX_STRUCT): return 8'h02;
      16'(IX_CTYPE):  return 8'h17;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic idx_writable(input logic [7:0] i);
    return (i == IX_CACHE) || (i == IX_PART) || (i == IX_BUSW) ||
           (i == IX_TIMING) || (i == IX_PWR);
  endfunction

  function automatic logic busw_legal(input logic [7:0] v);
    return (v == 8'd0) || (v == 8'd1) || (v == 8'd2) || (v == 8'd5) || (v == 8'd6);
  endfunction

endpackage

// File: rtl/ecsd_arg_decode.sv
module ecsd_arg_decode
  import ecsd_pkg::*;
(
  input  logic [31:0] arg_i,
  output sw_cmd_t     cmd_o
);
  always_comb begin
    cmd_o.mode    = acc_mode_e'(arg_i[25:24]);
    cmd_o.idx     = arg_i[23:16];
    cmd_o.val     = arg_i[15:8];
    cmd_o.cset    = arg_i[2:0];
    cmd_o.rsv_bad = (|arg_i[31:26]) | (|arg_i[7:3]);
  end
endmodule

// File: rtl/ecsd_byte_update.sv
module ecsd_byte_update
  import ecsd_pkg::*;
(
  input  sw_cmd_t    cmd_i,
  input  logic [7:0] cur_i,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_byte_o,
  output logic       fail_o
);
  logic [7:0] nxt;
  logic       bad_target;

  always_comb begin
    unique case (cmd_i.mode)
      AM_SETBITS: nxt = cur_i | cmd_i.val;
      AM_CLRBITS: nxt = cur_i & ~cmd_i.val;
      AM_WRBYTE:  nxt = cmd_i.val;
      default:    nxt = {5'd0, cmd_i.cset};
    endcase
    if (cmd_i.mode == AM_CMDSET) begin
      wr_idx_o   = IX_CSET;
      bad_target = 1'b0;
    end else begin
      wr_idx_o   = cmd_i.idx;
      bad_target = !idx_writable(cmd_i.idx) ||
                   ((cmd_i.idx == IX_BUSW) && !busw_legal(nxt));
    end
    wr_byte_o = nxt;
    fail_o    = cmd_i.rsv_bad | bad_target;
  end
endmodule

// File: rtl/ecsd_byte_ram.sv
module ecsd_byte_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ecsd_busy_timer.sv
module ecsd_busy_timer #(
  parameter int CYCLES = 6,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      cnt    <= CW'(CYCLES);
      busy_o <= 1'b1;
    end else begin
      busy_o <= (cnt > CW'(1));
      if (cnt != '0) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/ecsd_switch_unit.sv
module ecsd_switch_unit
  import ecsd_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int AW          = $clog2(DEPTH),
  parameter int BUSY_CYCLES = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid_i,
  input  logic [31:0]   cmd_arg_i,
  output logic          busy_o,
  output logic [31:0]   status_o,
  input  logic [AW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  localparam int BUSY_EFF = (BUSY_CYCLES < 2) ? 2 : BUSY_CYCLES;
  localparam int ERR_BIT  = 7;

  logic          init_q;
  logic [AW-1:0] init_addr;
  logic          tmr_busy;
  logic          accept;
  logic          mod_q;
  sw_cmd_t       live_cmd, cmd_q;
  logic [7:0]    cur_byte, wr_idx, wr_byte;
  logic          fail;
  logic          err_q;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  assign busy_o = init_q | tmr_busy;
  assign accept = cmd_valid_i & ~busy_o;

  ecsd_arg_decode u_dec (
    .arg_i (cmd_arg_i),
    .cmd_o (live_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q    <= 1'b1;
      init_addr <= '0;
    end else if (init_q) begin
      init_addr <= init_addr + AW'(1);
      if (init_addr == AW'(DEPTH - 1)) init_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q <= 1'b0;
      cmd_q <= '0;
      err_q <= 1'b0;
    end else begin
      mod_q <= accept;
      if (accept) cmd_q <= live_cmd;
      if (mod_q)  err_q <= fail;
    end
  end

  ecsd_busy_timer #(.CYCLES(BUSY_EFF)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .busy_o (tmr_busy)
  );

  ecsd_byte_update u_upd (
    .cmd_i     (cmd_q),
    .cur_i     (cur_byte),
    .wr_idx_o  (wr_idx),
    .wr_byte_o (wr_byte),
    .fail_o    (fail)
  );

  always_comb begin
    if (init_q) begin
      ram_we    = 1'b1;
      ram_addr  = init_addr;
      ram_wdata = reset_byte(16'(init_addr));
    end else if (mod_q) begin
      ram_we    = ~fail;
      ram_addr  = AW'(wr_idx);
      ram_wdata = wr_byte;
    end else begin
      ram_we    = 1'b0;
      ram_addr  = AW'(live_cmd.idx);
      ram_wdata = '0;
    end
  end

  ecsd_byte_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  (ram_addr),
    .a_wdata (ram_wdata),
    .a_rdata (cur_byte),
    .b_addr  (rd_idx_i),
    .b_rdata (rd_data_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[ERR_BIT] = err_q;
  end
endmodule

// File: rtl/ecsd_switch_chk.sv
module ecsd_switch_chk #(
  parameter int BUSY_CYCLES = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid_i,
  input logic        busy_o,
  input logic [31:0] status_o
);
  localparam int N = (BUSY_CYCLES < 2) ? 2 : BUSY_CYCLES;

  logic        init_done;
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_done <= 1'b0;
      run_cnt   <= '0;
    end else begin
      if (!busy_o) init_done <= 1'b1;
      run_cnt <= busy_o ? run_cnt + 16'd1 : 16'd0;
    end
  end

  p_busy_on_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !busy_o) |=> busy_o);

  p_status_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_o) |-> $stable(status_o));

  p_busy_max_r11: assert property (@(posedge clk) disable iff (rst)
    (init_done && busy_o) |-> (run_cnt < 16'(N)));

  p_busy_len_r12: assert property (@(posedge clk) disable iff (rst)
    (init_done && $fell(busy_o)) |-> (run_cnt == 16'(N)));
endmodule

bind ecsd_switch_unit ecsd_switch_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .status_o    (status_o)
);

// File: tb/ecsd_switch_unit_tb.sv
`timescale 1ns/1ps
module ecsd_switch_unit_tb;
  localparam int DEPTH = 512;
  localparam int AW    = 9;
  localparam int BUSY  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid_i = 1'b0;
  logic [31:0]   cmd_arg_i = '0;
  logic          busy_o;
  logic [31:0]   status_o;
  logic [AW-1:0] rd_idx_i = '0;
  logic [7:0]    rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic       mdl_err = 1'b0;

  always #2.5 clk = ~clk;

  ecsd_switch_unit #(.DEPTH(DEPTH), .AW(AW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_arg_i(cmd_arg_i),
    .busy_o(busy_o), .status_o(status_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] def_byte(input int i);
    if (i == 192) return 8'h08;
    if (i == 194) return 8'h02;
    if (i == 196) return 8'h17;
    return 8'h00;
  endfunction

  function automatic bit may_write(input int i);
    return i == 33 || i == 179 || i == 183 || i == 185 || i == 187;
  endfunction

  function automatic bit width_ok(input logic [7:0] v);
    return v == 0 || v == 1 || v == 2 || v == 5 || v == 6;
  endfunction

  function automatic logic [31:0] mk(input int mode, input int idx, input int val, input int cs);
    return {6'd0, mode[1:0], idx[7:0], val[7:0], 5'd0, cs[2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, output int tgt);
    logic [7:0] nv;
    int idx;
    idx = int'(a[23:16]);
    tgt = idx;
    mdl_err = 1'b0;
    if (a[31:26] != 0 || a[7:3] != 0) begin
      mdl_err = 1'b1;
      if (a[25:24] == 2'd0) tgt = 191;
    end else if (a[25:24] == 2'd0) begin
      tgt = 191;
      mdl[191] = {5'd0, a[2:0]};
    end else if (!may_write(idx)) begin
      mdl_err = 1'b1;
    end else begin
      case (a[25:24])
        2'd1:    nv = mdl[idx] | a[15:8];
        2'd2:    nv = mdl[idx] & ~a[15:8];
        default: nv = a[15:8];
      endcase
      if (idx == 183 && !width_ok(nv)) mdl_err = 1'b1;
      else mdl[idx] = nv;
    end
  endtask

  task automatic rd_byte(input int idx, output logic [7:0] v);
    @(negedge clk);
    rd_idx_i = AW'(idx);
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic check_byte(input string req, input int idx);
    logic [7:0] v;
    rd_byte(idx, v);
    chk(req, {24'd0, v}, {24'd0, mdl[idx]});
  endtask

  // issue one switch; optionally strobe a second one inside the busy window
  task automatic send(input logic [31:0] a, input string req, input bit extra, input logic [31:0] a2);
    int cnt;
    int tgt;
    while (busy_o) @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_arg_i   = a;
    @(negedge clk);
    if (extra) cmd_arg_i = a2;
    else cmd_valid_i = 1'b0;
    cnt = 0;
    while (busy_o) begin
      cnt++;
      @(negedge clk);
      cmd_valid_i = 1'b0;
    end
    chk(extra ? "R12 busy len" : "R11 busy len", cnt, BUSY);
    model(a, tgt);
    chk({req, " R10 status"}, status_o, {24'd0, mdl_err, 7'd0});
    check_byte(req, tgt);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mdl[i] = def_byte(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy in load", {31'd0, busy_o}, 32'd1);
    chk("R10 status reset", status_o, 32'd0);
    while (busy_o) @(negedge clk);
    check_byte("R1 rev", 192);
    check_byte("R1 struct", 194);
    check_byte("R1 ctype", 196);
    check_byte("R1 busw", 183);
    check_byte("R1 low", 0);
    check_byte("R13 top", 511);

    send(mk(3, 33, 8'hA5, 0), "R5 R2 write", 0, 0);
    send(mk(1, 33, 8'h0F, 0), "R3 or", 0, 0);
    send(mk(2, 33, 8'hA0, 0), "R4 clr", 0, 0);
    send(mk(0, 33, 8'hFF, 5), "R6 cset", 0, 0);
    check_byte("R6 idx ignored", 33);
    send(mk(3, 179, 8'h44, 0) | 32'h8000_0000, "R7 rsv hi", 0, 0);
    send(mk(3, 179, 8'h44, 0) | 32'h0000_0008, "R7 rsv lo", 0, 0);
    send(mk(3, 179, 8'h44, 0), "R10 clear", 0, 0);
    send(mk(3, 192, 8'h55, 0), "R8 rev ro", 0, 0);
    send(mk(1, 196, 8'h80, 0), "R8 ctype ro", 0, 0);
    send(mk(3, 183, 6, 0), "R9 w8ddr", 0, 0);
    send(mk(3, 183, 3, 0), "R9 bad3", 0, 0);
    send(mk(1, 183, 1, 0), "R9 or7", 0, 0);
    send(mk(2, 183, 2, 0), "R9 clr4", 0, 0);
    send(mk(3, 183, 5, 0), "R9 w4ddr", 0, 0);
    send(mk(3, 33, 8'h11, 0), "R12 first", 1, mk(3, 33, 8'h77, 0));
    check_byte("R12 ignored", 33);

    for (int k = 0; k < 80; k++) begin
      int pick;
      int idx;
      logic [31:0] a;
      int probe;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: idx = 33; 1: idx = 179; 2: idx = 183; 3: idx = 185; 4: idx = 187;
        5: idx = 192; 6: idx = 194; 7: idx = 196;
        default: idx = int'($urandom_range(0, 255));
      endcase
      a = mk(int'($urandom_range(0, 3)), idx,
             (idx == 183 && pick == 2) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 255)),
             int'($urandom_range(0, 7)));
      if ($urandom_range(0, 7) == 0) a[26 + $urandom_range(0, 5)] = 1'b1;
      if ($urandom_range(0, 7) == 0) a[3 + $urandom_range(0, 4)] = 1'b1;
      send(a, "R2 rand", 0, 0);
      probe = int'($urandom_range(0, DEPTH - 1));
      check_byte("R13 R8 probe", probe);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule